// File: doc/BRIEF.md
# Grouped Instruction Issue Splitter

This block sits between instruction fetch and the execution lanes. Fetch delivers 128-bit packets, each carrying three 41-bit instruction slots and a 5-bit template. The template marks the slots after which a parallel group closes. A group can be as short as one slot, and it can run across any number of packets. The compiler guarantees that slots inside one group do not depend on each other, so the block performs no dependency checks.

Slots are buffered in program order in a six-entry queue. Every cycle the block issues the next piece of the current group. A piece holds as many slots as the issue width allows and stops at the group's closing slot. A group wider than the machine therefore leaves as consecutive pieces.

When an issued branch turns out to be taken, the execution side raises a flush on the following cycle. The flush discards every slot still buffered, and issue resumes with the next packet accepted. Packets arrive over a valid/ready handshake. Ready drops while more than one packet's worth of slots is waiting.

Top module: `bsplit_issue`

## Requirements
- R1: After reset, no issue lane is valid and `pkt_ready` is high.
- R2: Slot s (s = 0, 1, 2) of a packet is bits [5+41*s+40 : 5+41*s]. Template bit s set means the group closes after slot s. Slots leave in program order: lane 0 carries the oldest slot issued in a cycle.
- R3: A cycle's piece never extends past a slot whose template bit closes the group. The next slot starts a new piece in the next cycle.
- R4: No more than ISSUE_W slots issue per cycle. A longer group is issued as consecutive pieces of ISSUE_W slots, with the last piece holding the remainder.
- R5: A group with no closing mark in a packet continues into the next accepted packet, and its slots issue together with that packet's slots.
- R6: `pkt_ready` is low whenever more than three slots are buffered. A packet offered while ready is low is neither lost nor duplicated; it is taken once ready returns.
- R7: In a cycle with `br_flush` high, no lane is valid and `pkt_ready` is low. In the cycle after, every slot that was buffered is gone.
- R8: After a flush, the first packet accepted issues from its slot 0.
- R9: Template bits [4:3] have no effect on grouping.
- R10: Valid lanes are always contiguous from lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside on the clock |
| pkt_valid | input | 1 | A packet is offered |
| pkt_data | input | 128 | Packet: three slots and a template |
| pkt_ready | output | 1 | Packet is taken at the edge when valid and ready are both high |
| br_flush | input | 1 | A branch issued in the previous cycle was taken |
| iss_valid | output | ISSUE_W | Per-lane issue valid, contiguous from lane 0 |
| iss_op | output | ISSUE_W*41 | Lane k holds bits [41k+40:41k] |

## Verification
Two functions can land on the same cycle.

The first pair is a flush and a packet offer. The bench holds a fresh packet valid through the flush cycle. It then checks that nothing issues during the flush and nothing issues after it, so the offered packet was refused along with the buffered slots.

The second pair is the width split and a packet boundary with the ready limit. A stop-free packet is followed at once by a packet whose first slot closes the group. The expected lane pattern 2+2+2 and a low ready in the middle cycle show the split, the group crossing the packet boundary, and backpressure together. A packet offered during that low-ready cycle must then appear exactly once.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  localparam int SLOT_W = 41;
  localparam int NSLOT  = 3;
  localparam int TMPL_W = 5;
  localparam int PKT_W  = TMPL_W + NSLOT * SLOT_W;

  typedef struct packed {
    logic              stop;
    logic [SLOT_W-1:0] op;
  } slot_t;

  // per-slot close-group marks taken from the low template bits
  function automatic logic [NSLOT-1:0] stop_mask(input logic [NSLOT-1:0] tmpl_lo);
    return tmpl_lo;
  endfunction

  function automatic slot_t [NSLOT-1:0] unpack_pkt(input logic [PKT_W-1:0] pkt);
    slot_t [NSLOT-1:0] s;
    logic  [NSLOT-1:0] m;
    m = stop_mask(pkt[NSLOT-1:0]);
    for (int i = 0; i < NSLOT; i++) begin
      s[i].op   = pkt[TMPL_W + i*SLOT_W +: SLOT_W];
      s[i].stop = m[i];
    end
    return s;
  endfunction
endpackage

// File: rtl/bsplit_pick.sv
module bsplit_pick #(
  parameter int W  = 2,
  parameter int CW = 3
) (
  input  logic [CW-1:0] avail,
  input  logic [W-1:0]  stops,
  input  logic          hold,
  output logic [CW-1:0] take_n
);
  logic open;

  always_comb begin
    take_n = '0;
    open   = 1'b1;
    for (int k = 0; k < W; k++) begin
      if (open && (CW'(k) < avail)) begin
        take_n = CW'(k + 1);
        if (stops[k]) open = 1'b0;
      end else begin
        open = 1'b0;
      end
    end
    if (hold) take_n = '0;
  end
endmodule

// File: rtl/bsplit_queue.sv
module bsplit_queue import bsplit_pkg::*; #(
  parameter int DEPTH  = 6,
  parameter int HEAD_N = 2,
  parameter int CW     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     push,
  input  slot_t [NSLOT-1:0]        push_slots,
  input  logic  [CW-1:0]           pop_n,
  output slot_t [HEAD_N-1:0]       head,
  output logic  [CW-1:0]           count
);
  slot_t [DEPTH-1:0] q, q_n;
  logic  [CW-1:0]    count_n, base;
  logic              upd_en;

  always_comb begin
    base = count - pop_n;
    for (int i = 0; i < DEPTH; i++) begin
      q_n[i] = '0;
      for (int s = 0; s < DEPTH; s++)
        if (s == i + int'(pop_n)) q_n[i] = q[s];
    end
    for (int i = 0; i < DEPTH; i++)
      for (int j = 0; j < NSLOT; j++)
        if (push && (i == int'(base) + j)) q_n[i] = push_slots[j];
    count_n = flush ? '0 : (base + (push ? CW'(NSLOT) : '0));
    upd_en  = flush | push | (pop_n != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      count <= '0;
    end else if (upd_en) begin
      q     <= q_n;
      count <= count_n;
    end
  end

  for (genvar k = 0; k < HEAD_N; k++) begin : g_head
    assign head[k] = q[k];
  end
endmodule

// File: rtl/bsplit_issue.sv
module bsplit_issue import bsplit_pkg::*; #(
  parameter int ISSUE_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pkt_valid,
  input  logic [PKT_W-1:0]          pkt_data,
  output logic                      pkt_ready,
  input  logic                      br_flush,
  output logic [ISSUE_W-1:0]        iss_valid,
  output logic [ISSUE_W*SLOT_W-1:0] iss_op
);
  localparam int QDEPTH = 2 * NSLOT;
  localparam int ROOM   = QDEPTH - NSLOT;
  localparam int CW     = $clog2(QDEPTH + 1);

  logic [1:0]              rst_sh;
  logic                    rst_s_n;
  slot_t [NSLOT-1:0]       in_slots;
  slot_t [ISSUE_W-1:0]     head;
  logic  [ISSUE_W-1:0]     hd_stop;
  logic  [CW-1:0]          occ, take_n;
  logic                    push;
  logic                    unused_tmpl_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_s_n = rst_sh[1];

  assign unused_tmpl_hi = ^pkt_data[TMPL_W-1:NSLOT];
  assign in_slots  = unpack_pkt(pkt_data);
  assign pkt_ready = !br_flush && (occ <= CW'(ROOM));
  assign push      = pkt_valid && pkt_ready;

  bsplit_queue #(.DEPTH(QDEPTH), .HEAD_N(ISSUE_W), .CW(CW)) queue_i (
    .clk(clk), .rst_n(rst_s_n), .flush(br_flush), .push(push),
    .push_slots(in_slots), .pop_n(take_n), .head(head), .count(occ)
  );

  bsplit_pick #(.W(ISSUE_W), .CW(CW)) pick_i (
    .avail(occ), .stops(hd_stop), .hold(br_flush), .take_n(take_n)
  );

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_lane
    assign hd_stop[k]                   = head[k].stop;
    assign iss_op[k*SLOT_W +: SLOT_W]   = head[k].op;
    assign iss_valid[k]                 = (CW'(k) < take_n);
  end
endmodule

// File: rtl/bsplit_issue_chk.sv
module bsplit_issue_chk #(
  parameter int W  = 2,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_flush,
  input logic          pkt_ready,
  input logic [W-1:0]  iss_valid,
  input logic [W-1:0]  head_stop,
  input logic [CW-1:0] occ
);
  for (genvar k = 0; k + 1 < W; k++) begin : g_pair
    a_r10_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[k+1] |-> iss_valid[k]);
    a_r3_no_cross_stop: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[k+1] |-> !head_stop[k]);
  end

  a_r6_ready_room: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> (occ <= CW'(3)));
  a_r6_cap: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(6));
  a_r7_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    br_flush |-> (!pkt_ready && (iss_valid == '0)));
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    br_flush |=> (occ == '0));
endmodule

bind bsplit_issue bsplit_issue_chk #(.W(ISSUE_W), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_s_n), .br_flush(br_flush), .pkt_ready(pkt_ready),
  .iss_valid(iss_valid), .head_stop(hd_stop), .occ(occ)
);

// File: tb/bsplit_issue_tb.sv
module bsplit_issue_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         pkt_valid;
  logic [127:0] pkt_data;
  logic         pkt_ready;
  logic         br_flush;
  logic [1:0]   iss_valid;
  logic [81:0]  iss_op;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done  = 1'b0;

  always #5 clk = ~clk;

  bsplit_issue #(.ISSUE_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_ready(pkt_ready), .br_flush(br_flush), .iss_valid(iss_valid), .iss_op(iss_op)
  );

  function automatic logic [40:0] op(int id, int s);
    return {33'(id), 8'(s)};
  endfunction

  function automatic logic [127:0] mkp(logic [4:0] t, int id);
    return {op(id, 2), op(id, 1), op(id, 0), t};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string r, logic [1:0] ev, logic [40:0] e0, logic [40:0] e1);
    logic [81:0] got, exp;
    n_chk++;
    got = iss_op;
    exp = {e1, e0};
    if (!ev[0]) begin got[40:0]  = '0; exp[40:0]  = '0; end
    if (!ev[1]) begin got[81:41] = '0; exp[81:41] = '0; end
    if (iss_valid !== ev || got !== exp) begin
      n_bad++;
      $display("FAIL %s: valid=%b ops=%h expected valid=%b ops=%h", r, iss_valid, got, ev, exp);
    end
  endtask

  task automatic chk_rdy(string r, logic e);
    n_chk++;
    if (pkt_ready !== e) begin
      n_bad++;
      $display("FAIL %s: pkt_ready=%b expected %b", r, pkt_ready, e);
    end
  endtask

  task automatic send(logic [4:0] t, int id);
    pkt_valid = 1'b1;
    pkt_data  = mkp(t, id);
    tick();
    pkt_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", 2'b00, '0, '0);
    chk_rdy("R1", 1'b1);
  endtask

  task automatic t_each_stop();
    send(5'b00111, 1);
    chk("R2", 2'b01, op(1, 0), '0);
    tick(); chk("R2", 2'b01, op(1, 1), '0);
    tick(); chk("R2", 2'b01, op(1, 2), '0);
    tick(); chk("R2", 2'b00, '0, '0);
  endtask

  task automatic t_trunc();
    send(5'b00001, 2);
    chk("R3", 2'b01, op(2, 0), '0);
    tick(); chk("R3", 2'b11, op(2, 1), op(2, 2));
    tick(); chk("R3", 2'b00, '0, '0);
  endtask

  task automatic t_split();
    send(5'b00100, 3);
    chk("R4", 2'b11, op(3, 0), op(3, 1));
    tick(); chk("R4", 2'b01, op(3, 2), '0);
    tick(); chk("R4", 2'b00, '0, '0);
  endtask

  task automatic t_span();
    pkt_valid = 1'b1;
    pkt_data  = mkp(5'b00000, 4);
    tick();
    chk("R5", 2'b11, op(4, 0), op(4, 1));
    chk_rdy("R6", 1'b1);
    pkt_data = mkp(5'b00001, 5);
    tick();
    chk("R5", 2'b11, op(4, 2), op(5, 0));
    chk_rdy("R6", 1'b0);
    pkt_data = mkp(5'b00111, 6);
    tick();
    chk("R5", 2'b11, op(5, 1), op(5, 2));
    chk_rdy("R6", 1'b1);
    tick();
    pkt_valid = 1'b0;
    chk("R6", 2'b01, op(6, 0), '0);
    tick(); chk("R6", 2'b01, op(6, 1), '0);
    tick(); chk("R6", 2'b01, op(6, 2), '0);
    tick(); chk("R6", 2'b00, '0, '0);
  endtask

  task automatic t_flush();
    pkt_valid = 1'b1;
    pkt_data  = mkp(5'b00000, 7);
    tick();
    chk("R7", 2'b11, op(7, 0), op(7, 1));
    pkt_data = mkp(5'b00100, 8);
    tick();
    br_flush = 1'b1;
    pkt_data = mkp(5'b00111, 9);
    #1;
    chk("R7", 2'b00, '0, '0);
    chk_rdy("R7", 1'b0);
    tick();
    br_flush  = 1'b0;
    pkt_valid = 1'b0;
    #1;
    chk("R7", 2'b00, '0, '0);
    chk_rdy("R7", 1'b1);
    tick(); chk("R7", 2'b00, '0, '0);
    send(5'b00111, 10);
    chk("R8", 2'b01, op(10, 0), '0);
    tick(); chk("R8", 2'b01, op(10, 1), '0);
    tick(); chk("R8", 2'b01, op(10, 2), '0);
    tick(); chk("R8", 2'b00, '0, '0);
  endtask

  task automatic t_hi_bits();
    send(5'b11001, 11);
    chk("R9", 2'b01, op(11, 0), '0);
    tick(); chk("R9", 2'b11, op(11, 1), op(11, 2));
    tick(); chk("R9", 2'b00, '0, '0);
    send(5'b10110, 12);
    chk("R9", 2'b11, op(12, 0), op(12, 1));
    tick(); chk("R10", 2'b01, op(12, 2), '0);
    tick(); chk("R10", 2'b00, '0, '0);
  endtask

  initial begin
    rst_n = 1'b0; pkt_valid = 1'b0; pkt_data = '0; br_flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_each_stop();
    t_trunc();
    t_split();
    t_span();
    t_flush();
    t_hi_bits();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule